// File: doc/BRIEF.md
# Inbound Doorbell Queue Writer

This block takes inbound doorbell events, each made of an 8-bit source ID, an 8-bit target ID and a 16-bit info word. It writes every event as one 8-byte record into a circular ring in memory. The ring has 512 records, which is 4 KiB. Two address registers track the ring. The enqueue pointer is where the block writes the next record. The dequeue pointer is the record that software reads next. Software loads both pointers with the ring base at setup. It retires a record by writing a self-clearing advance bit in the mode register.

Doorbells arrive on a valid/ready stream. The block accepts one only when all of these hold:
- the unit is enabled;
- no record write is outstanding;
- the ring has room.

A doorbell held on the input while the ring is full is not written. It raises the queue-full status flag and waits. Records leave on a valid/ready memory write port, one 64-bit beat per record. The address and data of a beat stay frozen while the memory holds ready low. Three sticky status flags are each cleared by writing 1 to them:
- record queued;
- queue full;
- reception error.

The interrupt output is the OR of the flags whose enable bits are set.

Top module: `dbq_writer`

## Requirements
- R1: After reset, all four registers read 0, and `db_ready`, `mw_valid` and `irq` are 0.
- R2: The record is big-endian, with byte 0 in `mw_data[63:56]`. The layout is:
  - byte 3 (`mw_data[39:32]`) holds the target ID;
  - byte 5 (`mw_data[23:16]`) holds the source ID;
  - bytes 6 and 7 (`mw_data[15:0]`) hold the info word, high byte first;
  - every other byte is zero.
- R3: A record is written at the address held in the enqueue pointer (register 3). When the write beat completes, that pointer advances by 8.
- R4: `db_ready` is high only when all three hold: mode bit 0 (enable) is 1, no write is outstanding, and the ring is not full. While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold steady.
- R5: Status bit 0 (record queued) is set on every completed record write. Writing 1 to it clears it. If a clear and a new set fall in the same cycle, the flag ends up set.
- R6: Writing a mode value with bit 1 set advances the dequeue pointer (register 2) by 8. Bit 1 always reads back 0. The advance is ignored when the two pointers are equal (empty ring).
- R7: A pointer advances only within its low 12 bits: offset 0xFF8 wraps to 0x000 and the bits above stay unchanged.
- R8: The ring is full when the enqueue pointer, after advancing, would equal the dequeue pointer. While the ring is full, an enabled doorbell with no write outstanding is not accepted. It sets status bit 4 (queue full), and the enqueue pointer does not move.
- R9: A one-cycle pulse on `rx_err` sets status bit 7 (reception error). Writing 1 to that bit clears it.
- R10: `irq` is the OR of the enabled status flags. Mode bit 4 enables status bit 0, mode bit 5 enables status bit 4, and mode bit 6 enables status bit 7.
- R11: Register writes to address 2 and address 3 load the dequeue and enqueue pointers, and the loaded values read back. Address 0 is the mode register and address 1 is the status register.
- R12: Clearing mode bit 0 stops new doorbells from being accepted. A record write that is already outstanding still completes and still advances the enqueue pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| db_valid | input | 1 | Doorbell event present |
| db_ready | output | 1 | Doorbell accepted on this edge when valid |
| db_src | input | 8 | Source ID of the doorbell |
| db_tgt | input | 8 | Target ID of the doorbell |
| db_info | input | 16 | Info word of the doorbell |
| rx_err | input | 1 | Reception error pulse |
| mw_valid | output | 1 | Record write beat present |
| mw_ready | input | 1 | Memory takes the beat on this edge |
| mw_addr | output | ADDR_W | Byte address of the record |
| mw_data | output | 64 | Record contents, big-endian |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 status, 2 dequeue, 3 enqueue |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can hit the same flag in the same cycle: a record write finishing and software clearing the record-queued flag by writing 1 to it. To provoke this, the bench holds a record beat stalled. It then raises `mw_ready` in the very cycle it issues the clear. It reads the status register afterwards and expects the flag still set. The bench also loads the dequeue pointer equal to the enqueue pointer and then requests an advance. It judges that the advance is ignored by reading the dequeue pointer back, which must be unchanged.

// File: rtl/dbq_pkg.sv
package dbq_pkg;

  localparam int REC_BYTES = 8;
  localparam int REC_BITS  = REC_BYTES * 8;

  typedef struct packed {
    logic [7:0]  src;
    logic [7:0]  tgt;
    logic [15:0] info;
  } dbell_t;

  // status flag indices inside the internal flag vector
  localparam int FLG_QUEUED = 0;
  localparam int FLG_FULL   = 1;
  localparam int FLG_ERR    = 2;
  localparam int NUM_FLG    = 3;

  // register-visible bit positions
  localparam int ST_QUEUED_BIT = 0;
  localparam int ST_FULL_BIT   = 4;
  localparam int ST_ERR_BIT    = 7;
  localparam int MD_EN_BIT     = 0;
  localparam int MD_ADV_BIT    = 1;
  localparam int MD_IE_LSB     = 4;

  // big-endian 8-byte record: byte 0 is the most significant
  function automatic logic [REC_BITS-1:0] pack_record(input dbell_t d);
    logic [REC_BITS-1:0] r;
    r        = '0;
    r[39:32] = d.tgt;
    r[23:16] = d.src;
    r[15:0]  = d.info;
    return r;
  endfunction

endpackage

// File: rtl/dbq_ring_ptr.sv
module dbq_ring_ptr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_next
);
  localparam logic [OFF_W-1:0] STEP = OFF_W'(dbq_pkg::REC_BYTES);

  logic [ADDR_W-1:0] ptr_q;
  logic [OFF_W-1:0]  off_inc;

  assign off_inc  = ptr_q[OFF_W-1:0] + STEP;
  assign ptr_next = {ptr_q[ADDR_W-1:OFF_W], off_inc};
  assign ptr      = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= load_val;
    else if (step) ptr_q <= ptr_next;
  end
endmodule

// File: rtl/dbq_status.sv
module dbq_status #(
  parameter int NF = dbq_pkg::NUM_FLG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] ie,
  output logic [NF-1:0] flags,
  output logic          irq
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n)      f_q <= 1'b0;
      else if (set[i]) f_q <= 1'b1;   // set wins over clear
      else if (clr[i]) f_q <= 1'b0;
    end
    assign flags[i] = f_q;
  end

  assign irq = |(flags & ie);
endmodule

// File: rtl/dbq_wr_stage.sv
module dbq_wr_stage #(
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  dbq_pkg::dbell_t               ev,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          mw_ready,
  output logic                          mw_valid,
  output logic [ADDR_W-1:0]             mw_addr,
  output logic [dbq_pkg::REC_BITS-1:0]  mw_data,
  output logic                          done
);
  logic                         vld_q;
  logic [ADDR_W-1:0]            addr_q;
  logic [dbq_pkg::REC_BITS-1:0] data_q;

  assign done = vld_q && mw_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      addr_q <= addr;
      data_q <= dbq_pkg::pack_record(ev);
    end else if (done) begin
      vld_q  <= 1'b0;
    end
  end

  assign mw_valid = vld_q;
  assign mw_addr  = addr_q;
  assign mw_data  = data_q;
endmodule

// File: rtl/dbq_writer.sv
module dbq_writer #(
  parameter int ADDR_W  = 32,
  parameter int NUM_REC = 512
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          db_valid,
  output logic                          db_ready,
  input  logic [7:0]                    db_src,
  input  logic [7:0]                    db_tgt,
  input  logic [15:0]                   db_info,
  input  logic                          rx_err,
  output logic                          mw_valid,
  input  logic                          mw_ready,
  output logic [ADDR_W-1:0]             mw_addr,
  output logic [dbq_pkg::REC_BITS-1:0]  mw_data,
  input  logic                          reg_wr,
  input  logic [1:0]                    reg_addr,
  input  logic [ADDR_W-1:0]             reg_wdata,
  output logic [ADDR_W-1:0]             reg_rdata,
  output logic                          irq
);
  import dbq_pkg::*;

  localparam int OFF_W = $clog2(NUM_REC) + $clog2(REC_BYTES);

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DEQ  = 2'd2;
  localparam logic [1:0] A_ENQ  = 2'd3;

  // mode register
  logic                mode_en;
  logic [NUM_FLG-1:0]  mode_ie;
  logic                wr_mode, wr_stat, wr_deq, wr_enq;

  assign wr_mode = reg_wr && (reg_addr == A_MODE);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_deq  = reg_wr && (reg_addr == A_DEQ);
  assign wr_enq  = reg_wr && (reg_addr == A_ENQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_en <= 1'b0;
      mode_ie <= '0;
    end else if (wr_mode) begin
      mode_en <= reg_wdata[MD_EN_BIT];
      mode_ie <= reg_wdata[MD_IE_LSB +: NUM_FLG];
    end
  end

  // pointers
  logic [ADDR_W-1:0] deq_ptr, deq_next, enq_ptr, enq_next;
  logic              ring_empty, ring_full, adv_req, wr_done, pend;

  assign ring_empty = (deq_ptr == enq_ptr);
  assign ring_full  = (enq_next == deq_ptr);
  assign adv_req    = wr_mode && reg_wdata[MD_ADV_BIT] && !ring_empty;

  dbq_ring_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_deq (
    .clk(clk), .rst_n(rst_n), .load(wr_deq), .load_val(reg_wdata),
    .step(adv_req), .ptr(deq_ptr), .ptr_next(deq_next)
  );

  dbq_ring_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_enq (
    .clk(clk), .rst_n(rst_n), .load(wr_enq), .load_val(reg_wdata),
    .step(wr_done), .ptr(enq_ptr), .ptr_next(enq_next)
  );

  // intake and record write stage
  dbell_t ev;
  logic   take, blocked_full;

  assign ev           = '{src: db_src, tgt: db_tgt, info: db_info};
  assign pend         = mw_valid;
  assign db_ready     = mode_en && !pend && !ring_full;
  assign take         = db_valid && db_ready;
  assign blocked_full = db_valid && mode_en && !pend && ring_full;

  dbq_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .take(take), .ev(ev), .addr(enq_ptr),
    .mw_ready(mw_ready), .mw_valid(mw_valid), .mw_addr(mw_addr),
    .mw_data(mw_data), .done(wr_done)
  );

  // status
  logic [NUM_FLG-1:0] st_set, st_clr, st_flags;

  always_comb begin
    st_set             = '0;
    st_set[FLG_QUEUED] = wr_done;
    st_set[FLG_FULL]   = blocked_full;
    st_set[FLG_ERR]    = rx_err;
    st_clr             = '0;
    st_clr[FLG_QUEUED] = wr_stat && reg_wdata[ST_QUEUED_BIT];
    st_clr[FLG_FULL]   = wr_stat && reg_wdata[ST_FULL_BIT];
    st_clr[FLG_ERR]    = wr_stat && reg_wdata[ST_ERR_BIT];
  end

  dbq_status #(.NF(NUM_FLG)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr), .ie(mode_ie),
    .flags(st_flags), .irq(irq)
  );

  // register read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE: begin
        reg_rdata[MD_EN_BIT]              = mode_en;
        reg_rdata[MD_IE_LSB +: NUM_FLG]   = mode_ie;
      end
      A_STAT: begin
        reg_rdata[ST_QUEUED_BIT] = st_flags[FLG_QUEUED];
        reg_rdata[ST_FULL_BIT]   = st_flags[FLG_FULL];
        reg_rdata[ST_ERR_BIT]    = st_flags[FLG_ERR];
      end
      A_DEQ:   reg_rdata = deq_ptr;
      default: reg_rdata = enq_ptr;
    endcase
  end
endmodule

// File: rtl/dbq_writer_chk.sv
module dbq_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              db_valid,
  input logic              db_ready,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [ADDR_W-1:0] mw_addr,
  input logic [63:0]       mw_data,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [ADDR_W-1:0] enq_ptr,
  input logic              mode_en,
  input logic [2:0]        st_flags
);
  localparam logic [OFF_W-1:0] STEP = OFF_W'(8);

  // R4: an accepted doorbell never lands on an outstanding write
  assert_accept_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && db_ready) |-> !mw_valid);

  // R4: back-pressure holds the beat
  assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  // R12: disabled unit never offers ready
  assert_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> !db_ready);

  // R3 / R7: completed write steps the enqueue offset by one record, base kept
  assert_enq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && mw_ready && !(reg_wr && reg_addr == 2'd3)) |=>
      (enq_ptr[OFF_W-1:0] == $past(enq_ptr[OFF_W-1:0]) + STEP) &&
      (enq_ptr[ADDR_W-1:OFF_W] == $past(enq_ptr[ADDR_W-1:OFF_W])));

  // R5: completed write leaves the queued flag set
  assert_queued_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && mw_ready) |=> st_flags[0]);
endmodule

bind dbq_writer dbq_writer_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_ready(db_ready),
  .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
  .mw_data(mw_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .enq_ptr(enq_ptr), .mode_en(mode_en), .st_flags(st_flags)
);

// File: tb/test_dbq_writer.sv
module test_dbq_writer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam logic [AW-1:0] BASE = 32'h0001_0000;
  // {src, tgt, info}
  localparam logic [31:0] VEC [0:5] = '{
    32'h12_34_ABCD, 32'h00_00_0000, 32'hFF_FF_FFFF,
    32'h01_80_8001, 32'hA5_5A_00FF, 32'h7E_E7_1234
  };

  logic clk = 0, rst_n = 0;
  logic db_valid = 0, db_ready, rx_err = 0;
  logic [7:0] db_src = 0, db_tgt = 0;
  logic [15:0] db_info = 0;
  logic mw_valid, mw_ready = 1;
  logic [AW-1:0] mw_addr;
  logic [63:0] mw_data;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [AW-1:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbq_writer i_dbq_writer (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_ready(db_ready),
    .db_src(db_src), .db_tgt(db_tgt), .db_info(db_info), .rx_err(rx_err),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr),
    .mw_data(mw_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_rec(input logic [7:0] s, input logic [7:0] t,
                                          input logic [15:0] inf);
    logic [7:0] b [0:7];
    for (int k = 0; k < 8; k++) b[k] = 8'h00;
    b[3] = t; b[5] = s; b[6] = inf[15:8]; b[7] = inf[7:0];
    return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [AW-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // present a doorbell and return at the negedge after it was accepted
  task automatic send(input logic [31:0] v);
    @(negedge clk);
    db_valid = 1; {db_src, db_tgt, db_info} = v;
    while (!db_ready) @(negedge clk);
    @(negedge clk);
    db_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R1 reg", r, 0);
    end
    chk("R1 ready/valid/irq", {db_ready, mw_valid, irq}, 3'b000);

    // R11 setup
    wr(2, BASE); wr(3, BASE); wr(0, 32'h71);
    rd(3, r); chk("R11 enq load", r, BASE);
    rd(2, r); chk("R11 deq load", r, BASE);

    // table walk: R2 layout, R3 address, R5 flag, R10 irq
    for (int i = 0; i < 6; i++) begin
      send(VEC[i]);
      chk("R3 addr", mw_addr, BASE + AW'(8*i));
      chk("R2 data", mw_data, exp_rec(VEC[i][31:24], VEC[i][23:16], VEC[i][15:0]));
      @(negedge clk);
      rd(3, r); chk("R3 enq step", r, BASE + AW'(8*(i+1)));
      rd(1, r); chk("R5 queued", r[0], 1);
      chk("R10 irq", irq, 1);
      wr(1, 32'h1);
    end
    rd(1, r); chk("R5 w1c", r, 0);
    chk("R10 irq low", irq, 0);

    // R4 back-pressure hold
    mw_ready = 0;
    send(32'h11_22_3344);
    repeat (3) @(negedge clk);
    chk("R4 hold valid", mw_valid, 1);
    chk("R4 hold ready", db_ready, 0);
    chk("R4 hold data", mw_data, exp_rec(8'h11, 8'h22, 16'h3344));
    chk("R4 hold addr", mw_addr, BASE + AW'(48));
    // R5 set wins over same-cycle clear
    @(negedge clk);
    mw_ready = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 0;
    rd(1, r); chk("R5 set wins", r[0], 1);
    wr(1, 32'h1);

    // R6 advance
    wr(0, 32'h73);
    rd(2, r); chk("R6 deq adv", r, BASE + 8);
    rd(0, r); chk("R6 bit1 reads 0", r, 32'h71);
    // R6 empty: advance ignored
    wr(2, BASE + 56); wr(0, 32'h73);
    rd(2, r); chk("R6 empty ignore", r, BASE + 56);

    // R7 wrap
    wr(2, BASE + 32'hFF8); wr(3, BASE + 32'hFF8);
    send(32'h09_08_0706);
    chk("R7 addr", mw_addr, BASE + 32'hFF8);
    @(negedge clk);
    rd(3, r); chk("R7 enq wrap", r, BASE);
    wr(0, 32'h73);
    rd(2, r); chk("R7 deq wrap", r, BASE);
    wr(1, 32'h91);

    // R8 full
    wr(2, BASE + 16); wr(3, BASE + 8);
    @(negedge clk);
    db_valid = 1; {db_src, db_tgt, db_info} = 32'hDE_AD_BEEF;
    #1 chk("R8 not ready", db_ready, 0);
    @(negedge clk);
    @(negedge clk);
    db_valid = 0;
    rd(1, r); chk("R8 full flag", r, 32'h10);
    chk("R8 irq", irq, 1);
    rd(3, r); chk("R8 enq kept", r, BASE + 8);
    chk("R8 no write", mw_valid, 0);
    wr(1, 32'h10);

    // R9 error
    @(negedge clk); rx_err = 1; @(negedge clk); rx_err = 0;
    rd(1, r); chk("R9 err set", r, 32'h80);
    chk("R10 err irq", irq, 1);
    wr(0, 32'h31);
    chk("R10 masked", irq, 0);
    wr(1, 32'h80);
    rd(1, r); chk("R9 err clr", r, 0);

    // R12 disable, pending write still completes
    wr(2, BASE); wr(3, BASE);
    mw_ready = 0;
    send(32'h55_66_7788);
    wr(0, 32'h0);
    @(negedge clk);
    db_valid = 1;
    #1 chk("R12 ready off", db_ready, 0);
    mw_ready = 1;
    @(negedge clk);
    db_valid = 0;
    rd(3, r); chk("R12 pend done", r, BASE + 8);
    @(negedge clk);
    chk("R12 no new write", mw_valid, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule